// File: doc/BRIEF.md
# Arithmetic, Logic and Shift Datapath Slice

This block is a purely combinational datapath slice that turns two operand words, a four-bit operation code and a carry input into one result word and a carry output. The two upper code bits pick one of three engines. The first is an adder whose second operand comes from a per-bit selector. The second is a bitwise logic unit. The third moves the first operand one place left or right.

The adder has no separate subtractor, incrementer or decrementer. Its second operand is steered to zeros, B, the inverse of B or ones, and the carry input is added in. One code can therefore give transfer, increment, add, add-with-carry, subtract-with-borrow, subtract or decrement, depending on the carry bit. Each shift direction has its own serial input, which fills the vacated end of the word.

The word width is a parameter. The adder can be built as an explicit ripple chain or as a behavioural sum, and a parameter picks which.

Top module: `alsu_core`

## Requirements
- R1: With op_sel[3:2] = 00, f equals (a + y + carry_in) modulo 2^WIDTH. y is selected by op_sel[1:0]: 00 all zeros, 01 b, 10 bitwise inverse of b, 11 all ones.
- R2: With op_sel[3:2] = 00, carry_out equals bit WIDTH of the full sum a + y + carry_in.
- R3: Code 0000 passes a through unchanged with carry_in 0 and gives a+1 with carry_in 1. The all-ones word wraps to zero with carry_out 1.
- R4: Code 0011 gives a−1 with carry_in 0, so zero becomes all ones with carry_out 0. With carry_in 1 it gives a with carry_out 1.
- R5: Code 0010 with carry_in 1 gives a−b, with carry_out 1 exactly when a ≥ b unsigned. With carry_in 0 it gives a−b−1.
- R6: With op_sel[3:2] = 01, op_sel[1:0] chooses 00 a&b, 01 a|b, 10 a^b, 11 ~a. carry_in has no effect on f.
- R7: With op_sel[3:2] = 10, f[i] = a[i+1] for i < WIDTH−1 and f[WIDTH−1] = shr_fill. op_sel[1:0] and carry_in have no effect.
- R8: With op_sel[3:2] = 11, f[i] = a[i−1] for i > 0 and f[0] = shl_fill. op_sel[1:0] and carry_in have no effect.
- R9: carry_out is 0 whenever op_sel[3:2] is not 00.
- R10: shr_fill and shl_fill have no effect on f except through the shift code that uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code: [3:2] pick the engine, [1:0] pick the variant |
| carry_in | input | 1 | Carry added into the adder sum |
| a | input | WIDTH | First operand, and the shifted word |
| b | input | WIDTH | Second operand |
| shr_fill | input | 1 | Bit that enters the top position on a right shift |
| shl_fill | input | 1 | Bit that enters the bottom position on a left shift |
| f | output | WIDTH | Result word |
| carry_out | output | 1 | Adder carry in arithmetic mode, 0 otherwise |

## Verification
The bench targets the wrap points of the adder. All-ones plus one must give zero with a carry. Zero minus one must give all ones without a carry. Equal operands under subtraction must give zero with a carry. A design with an inverted or dropped carry, or with a wrong operand selector, gives a wrong word or a wrong carry_out at these points. The bench drives a toggled carry_in and opposite fill bits into the logic and shift codes, so a design that leaks them, or that swaps the two fill inputs, shows a changed top or bottom bit. It also checks that carry_out is held low outside arithmetic mode, which catches a design that lets the adder carry leak through.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
   typedef enum logic [1:0] {
      SRC_ARITH = 2'b00,
      SRC_LOGIC = 2'b01,
      SRC_SHR   = 2'b10,
      SRC_SHL   = 2'b11
   } alsu_src_e;

   typedef enum logic [1:0] {
      YSEL_ZERO = 2'b00,
      YSEL_B    = 2'b01,
      YSEL_NOTB = 2'b10,
      YSEL_ONES = 2'b11
   } alsu_ysel_e;

   typedef enum logic [1:0] {
      LOP_AND = 2'b00,
      LOP_OR  = 2'b01,
      LOP_XOR = 2'b10,
      LOP_NOT = 2'b11
   } alsu_lop_e;

   localparam int ADDER_RIPPLE     = 0;
   localparam int ADDER_BEHAVIORAL = 1;
endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
   import alsu_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int ADDER_STYLE = ADDER_RIPPLE
) (
   input  logic [1:0]       ysel,
   input  logic             cin,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   logic [WIDTH-1:0] y;

   // per-bit operand steering
   for (genvar i = 0; i < WIDTH; i++) begin : g_ymux
      always_comb begin
         unique case (alsu_ysel_e'(ysel))
            YSEL_ZERO: y[i] = 1'b0;
            YSEL_B:    y[i] = b[i];
            YSEL_NOTB: y[i] = ~b[i];
            YSEL_ONES: y[i] = 1'b1;
            default:   y[i] = 1'b0;
         endcase
      end
   end

   if (ADDER_STYLE == ADDER_RIPPLE) begin : g_ripple
      logic [WIDTH:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_fa
         assign sum[i]  = a[i] ^ y[i] ^ c[i];
         assign c[i+1]  = (a[i] & y[i]) | (c[i] & (a[i] ^ y[i]));
      end
      assign cout = c[WIDTH];
   end else if (ADDER_STYLE == ADDER_BEHAVIORAL) begin : g_behav
      logic [WIDTH:0] wide;
      assign wide = {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
      assign sum  = wide[WIDTH-1:0];
      assign cout = wide[WIDTH];
   end else begin : g_bad_style
      $error("alsu_arith: unknown ADDER_STYLE %0d", ADDER_STYLE);
   end
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
   import alsu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [1:0]       lop,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] res
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         unique case (alsu_lop_e'(lop))
            LOP_AND: res[i] = a[i] & b[i];
            LOP_OR:  res[i] = a[i] | b[i];
            LOP_XOR: res[i] = a[i] ^ b[i];
            LOP_NOT: res[i] = ~a[i];
            default: res[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
   parameter int WIDTH = 16
) (
   input  logic             to_left,
   input  logic [WIDTH-1:0] a,
   input  logic             fill_r,
   input  logic             fill_l,
   output logic [WIDTH-1:0] res
);
   localparam int TOP = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_up;
      logic from_down;
      if (i == TOP) begin : g_top
         assign from_up = fill_r;
      end else begin : g_mid_up
         assign from_up = a[i+1];
      end
      if (i == 0) begin : g_bot
         assign from_down = fill_l;
      end else begin : g_mid_dn
         assign from_down = a[i-1];
      end
      assign res[i] = to_left ? from_down : from_up;
   end
endmodule

// File: rtl/alsu_core.sv
module alsu_core
   import alsu_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int ADDER_STYLE = ADDER_RIPPLE
) (
   input  logic [3:0]       op_sel,
   input  logic             carry_in,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             shr_fill,
   input  logic             shl_fill,
   output logic [WIDTH-1:0] f,
   output logic             carry_out
);
   if (WIDTH < 2) begin : g_width_chk
      $error("alsu_core: WIDTH must be at least 2, got %0d", WIDTH);
   end

   logic [WIDTH-1:0] arith_res;
   logic             arith_cout;
   logic [WIDTH-1:0] logic_res;
   logic [WIDTH-1:0] shift_res;
   alsu_src_e        src;

   assign src = alsu_src_e'(op_sel[3:2]);

   alsu_arith #(.WIDTH(WIDTH), .ADDER_STYLE(ADDER_STYLE)) u_arith (
      .ysel (op_sel[1:0]),
      .cin  (carry_in),
      .a    (a),
      .b    (b),
      .sum  (arith_res),
      .cout (arith_cout)
   );

   alsu_logic #(.WIDTH(WIDTH)) u_logic (
      .lop (op_sel[1:0]),
      .a   (a),
      .b   (b),
      .res (logic_res)
   );

   alsu_shift #(.WIDTH(WIDTH)) u_shift (
      .to_left (op_sel[2]),
      .a       (a),
      .fill_r  (shr_fill),
      .fill_l  (shl_fill),
      .res     (shift_res)
   );

   always_comb begin
      unique case (src)
         SRC_ARITH: begin
            f         = arith_res;
            carry_out = arith_cout;
         end
         SRC_LOGIC: begin
            f         = logic_res;
            carry_out = 1'b0;
         end
         SRC_SHR, SRC_SHL: begin
            f         = shift_res;
            carry_out = 1'b0;
         end
         default: begin
            f         = '0;
            carry_out = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/alsu_core_chk.sv
module alsu_core_chk #(
   parameter int WIDTH = 16
) (
   input logic [3:0]       op_sel,
   input logic             carry_in,
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             shr_fill,
   input logic             shl_fill,
   input logic [WIDTH-1:0] f,
   input logic             carry_out
);
   always_comb begin
      if (op_sel[3:2] != 2'b00)
         AST_CARRY_LOW_NONARITH: assert (carry_out == 1'b0); // R9
      if (op_sel == 4'b0001)
         AST_ADD_SUM: assert ({carry_out, f} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in})); // R1
      if (op_sel == 4'b0011 && carry_in)
         AST_ONES_PLUS_ONE_PASS: assert (f == a && carry_out); // R4
      if (op_sel == 4'b0111)
         AST_LOGIC_INVERT: assert (f == ~a); // R6
      if (op_sel[3:2] == 2'b10)
         AST_SHR_TOP_FILL: assert (f[WIDTH-1] == shr_fill && f[WIDTH-2:0] == a[WIDTH-1:1]); // R7
      if (op_sel[3:2] == 2'b11)
         AST_SHL_BOT_FILL: assert (f[0] == shl_fill && f[WIDTH-1:1] == a[WIDTH-2:0]); // R8
   end
endmodule

bind alsu_core alsu_core_chk #(.WIDTH(WIDTH)) u_alsu_core_chk (
   .op_sel    (op_sel),
   .carry_in  (carry_in),
   .a         (a),
   .b         (b),
   .shr_fill  (shr_fill),
   .shl_fill  (shl_fill),
   .f         (f),
   .carry_out (carry_out)
);

// File: tb/alsu_core_bench.sv
module alsu_core_bench;
   localparam int W = 16;
   localparam logic [W-1:0] ONES = '1;

   logic         clk = 1'b0;
   logic [3:0]   op_sel = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         shr_fill = 1'b0;
   logic         shl_fill = 1'b0;
   logic [W-1:0] f;
   logic         carry_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   alsu_core #(.WIDTH(W)) u_alsu_core (
      .op_sel(op_sel), .carry_in(carry_in), .a(a), .b(b),
      .shr_fill(shr_fill), .shl_fill(shl_fill),
      .f(f), .carry_out(carry_out)
   );

   function automatic logic [W:0] model(input logic [3:0] op, input logic ci,
                                        input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic fr, input logic fl);
      logic [W-1:0] opnd;
      logic [W:0]   r;
      case (op[3:2])
         2'b00: begin
            case (op[1:0])
               2'b00: opnd = '0;
               2'b01: opnd = y;
               2'b10: opnd = ~y;
               default: opnd = ONES;
            endcase
            r = {1'b0, x} + {1'b0, opnd} + {{W{1'b0}}, ci};
         end
         2'b01: begin
            case (op[1:0])
               2'b00: r = {1'b0, x & y};
               2'b01: r = {1'b0, x | y};
               2'b10: r = {1'b0, x ^ y};
               default: r = {1'b0, ~x};
            endcase
         end
         2'b10: r = {1'b0, fr, x[W-1:1]};
         default: r = {1'b0, x[W-2:0], fl};
      endcase
      return r;
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op[3:2])
         2'b00: case (op[1:0])
                   2'b00: return "R3/R2";
                   2'b10: return "R5/R2";
                   2'b11: return "R4/R2";
                   default: return "R1/R2";
                endcase
         2'b01: return "R6/R9";
         2'b10: return "R7/R9";
         default: return "R8/R9";
      endcase
   endfunction

   task automatic apply(input logic [3:0] op, input logic ci,
                        input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic fr, input logic fl, input string tag);
      logic [W:0] exp;
      @(negedge clk);
      op_sel = op; carry_in = ci; a = x; b = y; shr_fill = fr; shl_fill = fl;
      #1;
      exp = model(op, ci, x, y, fr, fl);
      checks++;
      if ({carry_out, f} !== exp) begin
         errors++;
         $display("FAIL %s op=%b ci=%b a=%h b=%h: got co=%b f=%h, expected co=%b f=%h",
                  tag, op, ci, x, y, carry_out, f, exp[W], exp[W-1:0]);
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // idle state after start: op 0000 with zeros
      apply(4'b0000, 1'b0, '0, '0, 1'b0, 1'b0, "R3 idle");
      // R3: increment wrap
      apply(4'b0000, 1'b1, ONES, 16'h1234, 1'b0, 1'b0, "R3 wrap");
      apply(4'b0000, 1'b0, 16'hBEEF, 16'h0, 1'b0, 1'b0, "R3 transfer");
      // R4: decrement of zero, transfer via ones
      apply(4'b0011, 1'b0, '0, 16'h5555, 1'b0, 1'b0, "R4 dec zero");
      apply(4'b0011, 1'b0, 16'h0100, 16'h0, 1'b0, 1'b0, "R4 dec");
      apply(4'b0011, 1'b1, 16'h7A7A, 16'h0, 1'b0, 1'b0, "R4 pass");
      // R5: subtract equal, smaller, with borrow
      apply(4'b0010, 1'b1, 16'h4000, 16'h4000, 1'b0, 1'b0, "R5 equal");
      apply(4'b0010, 1'b1, 16'h0003, 16'h0005, 1'b0, 1'b0, "R5 negative");
      apply(4'b0010, 1'b0, 16'h0009, 16'h0002, 1'b0, 1'b0, "R5 borrow");
      // R1/R2: add with carries
      apply(4'b0001, 1'b0, 16'h8000, 16'h8000, 1'b0, 1'b0, "R1 R2 carry");
      apply(4'b0001, 1'b1, ONES, '0, 1'b0, 1'b0, "R1 R2 cin ripple");
      // R6: logic with carry toggled
      for (int k = 0; k < 4; k++) begin
         apply({2'b01, k[1:0]}, 1'b0, 16'hF0CC, 16'hAA0F, 1'b1, 1'b1, "R6 R9 ci0");
         apply({2'b01, k[1:0]}, 1'b1, 16'hF0CC, 16'hAA0F, 1'b0, 1'b0, "R6 R9 ci1 R10");
      end
      // R7/R8/R10: shifts with opposite fills and all low-select values
      for (int k = 0; k < 4; k++) begin
         apply({2'b10, k[1:0]}, k[0], 16'h8001, 16'hFFFF, 1'b1, 1'b0, "R7 fill1 R10");
         apply({2'b10, k[1:0]}, k[1], 16'h8001, 16'h0000, 1'b0, 1'b1, "R7 fill0 R10");
         apply({2'b11, k[1:0]}, k[0], 16'h8001, 16'hFFFF, 1'b0, 1'b1, "R8 fill1 R10");
         apply({2'b11, k[1:0]}, k[1], 16'h8001, 16'h0000, 1'b1, 1'b0, "R8 fill0 R10");
      end
      // R10: fills have no effect in arithmetic
      apply(4'b0001, 1'b0, 16'h1111, 16'h2222, 1'b1, 1'b1, "R10 arith");
      // exhaustive op x carry sweep, random operands
      for (int rep = 0; rep < 64; rep++) begin
         for (int op = 0; op < 16; op++) begin
            for (int ci = 0; ci < 2; ci++) begin
               logic [W-1:0] ra;
               logic [W-1:0] rb;
               logic [3:0]   opv;
               ra = W'($urandom);
               rb = W'($urandom);
               opv = 4'(op);
               apply(opv, ci[0], ra, rb, 1'($urandom), 1'($urandom), tag_of(opv));
            end
         end
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule